// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words (1 sign bit, 8-bit biased exponent, 23-bit fraction) in a fixed three-stage pipeline. It accepts one operand pair on any cycle `in_valid` is high and returns the product three cycles later with `out_valid`, plus flags that mark an exponent overflow or underflow of the rounded result.

The first stage classifies each operand and adds the two biased exponent fields, taking away one bias. The second stage forms the 48-bit product of the two 24-bit significands, each with its hidden leading one. The third stage normalizes, rounds to nearest with ties to even, checks the exponent window and packs the word with the sign, which is the XOR of the operand signs. Operands with a zero exponent field count as zero, so subnormals are flushed. Any NaN operand, and infinity times zero, give one fixed quiet NaN.

Top module: `fpm_mul`

## Requirements
- R1: A pair sampled with `in_valid` high at clock edge k gives `out_valid` high for one cycle after edge k+3, in issue order. Back-to-back pairs are accepted on every cycle.
- R2: For every result that is not NaN, the sign bit [31] is the XOR of the operand sign bits.
- R3: For two normal operands, the biased result exponent is ea+eb-127. When the significand product is 2 or more, it is shifted right by one and the exponent rises by one. The fraction field [22:0] holds the 23 bits below the leading one.
- R4: Bits dropped by normalization round to nearest, ties to even. If rounding carries out of the significand, the fraction becomes zero and the exponent rises by one.
- R5: An operand with exponent field [30:23] equal to 0, whatever its fraction, counts as zero. Times a finite operand it gives a zero carrying the R2 sign, with both flags low.
- R6: If the biased exponent after rounding is 255 or more, the result is infinity (exponent 0xFF, fraction 0) with the R2 sign, and `ovf` is high.
- R7: If the biased exponent after rounding is 0 or less, the result is zero with the R2 sign, and `unf` is high.
- R8: An operand with exponent 0xFF and a nonzero fraction, or infinity times zero, gives 0x7FC00000 with both flags low.
- R9: Infinity times a nonzero finite value or infinity gives infinity with the R2 sign and both flags low.
- R10: While reset is asserted, and after it until a result is due, `out_valid`, `ovf` and `unf` are low.
- R11: `ovf` and `unf` are never high while `out_valid` is low, and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair valid |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result valid, one cycle per accepted pair |
| result | output | 32 | Product word |
| ovf | output | 1 | Result exponent overflowed, infinity returned |
| unf | output | 1 | Result exponent underflowed, zero returned |

## Verification
On every cycle, the assertions check the three-cycle valid latency, the sign rule, zero and NaN operands mapping to their fixed outputs, and the shape of flagged results: overflow means a signed infinity, underflow means a signed zero, and the two flags never meet. The numeric value of an ordinary product cannot be checked that way. Exact rounding, ties in either direction, the carry out of rounding and the edges of the exponent window only show up in the bench's scenarios. Those scenarios compare each result against an integer reference model and against hand-computed words.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fpm_cls_e;

  // Class of a product given the classes of its two factors.
  function automatic fpm_cls_e fpm_combine(fpm_cls_e a, fpm_cls_e b);
    fpm_cls_e r;
    if (a == CLS_NAN || b == CLS_NAN)
      r = CLS_NAN;
    else if ((a == CLS_INF && b == CLS_ZERO) || (a == CLS_ZERO && b == CLS_INF))
      r = CLS_NAN;
    else if (a == CLS_INF || b == CLS_INF)
      r = CLS_INF;
    else if (a == CLS_ZERO || b == CLS_ZERO)
      r = CLS_ZERO;
    else
      r = CLS_NUM;
    return r;
  endfunction

endpackage

// File: rtl/fpm_rst_sync.sv
module fpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output fpm_cls_e              cls,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       sig
);

  logic [FRAC_W-1:0] frac;
  logic              exp_zero;
  logic              exp_full;

  always_comb begin
    sign     = word[EXP_W+FRAC_W];
    exp_f    = word[EXP_W+FRAC_W-1:FRAC_W];
    frac     = word[FRAC_W-1:0];
    exp_zero = (exp_f == '0);
    exp_full = (exp_f == '1);
    // zero exponent: no hidden one (subnormals flush to zero)
    sig      = {~exp_zero, frac};
    if (exp_full)
      cls = (frac == '0) ? CLS_INF : CLS_NAN;
    else if (exp_zero)
      cls = CLS_ZERO;
    else
      cls = CLS_NUM;
  end

endmodule

// File: rtl/fpm_norm_round.sv
module fpm_norm_round
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int EW     = EXP_W + 2
) (
  input  logic [PROD_W-1:0]    prod,
  input  logic signed [EW-1:0] exp_in,
  input  logic                 sign,
  input  fpm_cls_e             cls,
  output logic [W-1:0]         result,
  output logic                 ovf,
  output logic                 unf
);

  localparam logic signed [EW-1:0] EXP_TOP  = EW'((1 << EXP_W) - 1);
  localparam logic signed [EW-1:0] EXP_NONE = '0;
  localparam logic [W-1:0]         QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                 hi;
  logic [FRAC_W-1:0]    frac_n;
  logic                 guard;
  logic                 sticky;
  logic                 up;
  logic [FRAC_W:0]      frac_sum;
  logic signed [EW-1:0] exp_n;
  logic signed [EW-1:0] exp_r;

  always_comb begin
    // product lies in [1,4): top bit set means [2,4)
    hi     = prod[PROD_W-1];
    frac_n = hi ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
    guard  = hi ? prod[FRAC_W] : prod[FRAC_W-1];
    sticky = hi ? (|prod[FRAC_W-1:0]) : (|prod[FRAC_W-2:0]);
    exp_n  = exp_in + EW'(hi);

    up       = guard & (sticky | frac_n[0]);
    frac_sum = {1'b0, frac_n} + (FRAC_W+1)'(up);
    exp_r    = exp_n + EW'(frac_sum[FRAC_W]);

    ovf    = 1'b0;
    unf    = 1'b0;
    unique case (cls)
      CLS_NAN:  result = QNAN;
      CLS_INF:  result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_ZERO: result = {sign, {(W-1){1'b0}}};
      default: begin
        if (exp_r >= EXP_TOP) begin
          result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf    = 1'b1;
        end else if (exp_r <= EXP_NONE) begin
          result = {sign, {(W-1){1'b0}}};
          unf    = 1'b1;
        end else begin
          result = {sign, exp_r[EXP_W-1:0], frac_sum[FRAC_W-1:0]};
        end
      end
    endcase
  end

endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  ovf,
  output logic                  unf
);

  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EW     = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int N_OPS  = 2;

  logic rst_sync_n;

  fpm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // ---------------- operand classification ----------------
  logic [W-1:0]       ops    [N_OPS];
  fpm_cls_e           cls_v  [N_OPS];
  logic               sign_v [N_OPS];
  logic [EXP_W-1:0]   exp_v  [N_OPS];
  logic [SIG_W-1:0]   sig_v  [N_OPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
      .word  (ops[gi]),
      .cls   (cls_v[gi]),
      .sign  (sign_v[gi]),
      .exp_f (exp_v[gi]),
      .sig   (sig_v[gi])
    );
  end

  // ---------------- stage 1: exponent sum, class ----------------
  logic                 v1_q;
  fpm_cls_e             s1_cls_d,  s1_cls_q;
  logic                 s1_sign_d, s1_sign_q;
  logic signed [EW-1:0] s1_exp_d,  s1_exp_q;
  logic [SIG_W-1:0]     s1_sa_q,   s1_sb_q;

  always_comb begin
    s1_cls_d  = fpm_combine(cls_v[0], cls_v[1]);
    s1_sign_d = sign_v[0] ^ sign_v[1];
    s1_exp_d  = EW'(exp_v[0]) + EW'(exp_v[1]) - EW'(BIAS);
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_cls_q  <= s1_cls_d;
      s1_sign_q <= s1_sign_d;
      s1_exp_q  <= s1_exp_d;
      s1_sa_q   <= sig_v[0];
      s1_sb_q   <= sig_v[1];
    end
  end

  // ---------------- stage 2: significand product ----------------
  logic              v2_q;
  logic [PROD_W-1:0] s2_prod_d, s2_prod_q;
  fpm_cls_e          s2_cls_q;
  logic              s2_sign_q;
  logic signed [EW-1:0] s2_exp_q;

  always_comb begin
    s2_prod_d = PROD_W'(s1_sa_q) * PROD_W'(s1_sb_q);
  end

  always_ff @(posedge clk) begin
    if (v1_q) begin
      s2_prod_q <= s2_prod_d;
      s2_cls_q  <= s1_cls_q;
      s2_sign_q <= s1_sign_q;
      s2_exp_q  <= s1_exp_q;
    end
  end

  // ---------------- stage 3: normalize, round, pack ----------------
  logic [W-1:0] res_d, res_q;
  logic         ovf_d, unf_d;
  logic         ovf_q, unf_q;
  logic         v3_q;

  fpm_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm_round (
    .prod   (s2_prod_q),
    .exp_in (s2_exp_q),
    .sign   (s2_sign_q),
    .cls    (s2_cls_q),
    .result (res_d),
    .ovf    (ovf_d),
    .unf    (unf_d)
  );

  always_ff @(posedge clk) begin
    if (v2_q) res_q <= res_d;
  end

  // ---------------- valid chain and flags ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      v1_q  <= in_valid;
      v2_q  <= v1_q;
      v3_q  <= v2_q;
      ovf_q <= v2_q & ovf_d;
      unf_q <= v2_q & unf_d;
    end
  end

  assign out_valid = v3_q;
  assign result    = res_q;
  assign ovf       = ovf_q;
  assign unf       = unf_q;

endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         ovf,
  input logic         unf
);

  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // cycles since reset release, saturating; gates the look-back checks
  logic [2:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)       age_q <= '0;
    else if (age_q != 3'd4) age_q <= age_q + 3'd1;
  end
  assign warm = (age_q == 3'd4);

  logic a_ez, b_ez, a_ef, b_ef, a_nan, b_nan;
  logic zero_in, nan_in, sign_in;
  logic res_ef, res_fz, res_mag0, res_nan;

  always_comb begin
    a_ez     = (op_a[W-2:FRAC_W] == '0);
    b_ez     = (op_b[W-2:FRAC_W] == '0);
    a_ef     = (op_a[W-2:FRAC_W] == '1);
    b_ef     = (op_b[W-2:FRAC_W] == '1);
    a_nan    = a_ef && (op_a[FRAC_W-1:0] != '0);
    b_nan    = b_ef && (op_b[FRAC_W-1:0] != '0);
    zero_in  = in_valid && (a_ez || b_ez) && !a_ef && !b_ef;
    nan_in   = in_valid && (a_nan || b_nan);
    sign_in  = op_a[W-1] ^ op_b[W-1];
    res_ef   = (result[W-2:FRAC_W] == '1);
    res_fz   = (result[FRAC_W-1:0] == '0);
    res_mag0 = (result[W-2:0] == '0);
    res_nan  = res_ef && !res_fz;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (warm && out_valid && !res_nan) |-> (result[W-1] == $past(sign_in, 3)));

  p_zero_in_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (warm && $past(zero_in, 3)) |-> (out_valid && res_mag0 && !ovf && !unf));

  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf |-> (out_valid && res_ef && res_fz));

  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unf |-> (out_valid && res_mag0));

  p_nan_in_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (warm && $past(nan_in, 3)) |-> (out_valid && result == QNAN && !ovf && !unf));

  p_nan_out_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && res_nan) |-> (result == QNAN));

  p_flags_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf || unf) |-> (out_valid && !(ovf && unf)));

endmodule

bind fpm_mul fpm_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpm_mul_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_b       (op_b),
  .out_valid  (out_valid),
  .result     (result),
  .ovf        (ovf),
  .unf        (unf)
);

// File: tb/tb_fpm_mul.sv
`timescale 1ns/1ps
module tb_fpm_mul;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf, unf;

  fpm_mul dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf),
    .unf       (unf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic        unf;
    int          issue;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    mon_en  = 0;
  bit    done    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Integer reference model written from the requirements.
  function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic o, output logic u);
    logic sg;
    int ea, eb, e, sh;
    longint unsigned p, q, rem, half;
    logic an, bn, ai, bi, az, bz;
    sg = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    an = (ea == 255) && (a[22:0] != 0);
    bn = (eb == 255) && (b[22:0] != 0);
    ai = (ea == 255) && (a[22:0] == 0);
    bi = (eb == 255) && (b[22:0] == 0);
    az = (ea == 0);
    bz = (eb == 0);
    o = 1'b0;
    u = 1'b0;
    if (an || bn || (ai && bz) || (bi && az)) r = 32'h7FC00000;
    else if (ai || bi) r = {sg, 8'hFF, 23'h0};
    else if (az || bz) r = {sg, 31'h0};
    else begin
      p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
      e = ea + eb - 127;
      if (p >= (64'd1 << 47)) begin sh = 24; e = e + 1; end
      else sh = 23;
      q    = p >> sh;
      rem  = p & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
      if (e >= 255)    begin r = {sg, 8'hFF, 23'h0}; o = 1'b1; end
      else if (e <= 0) begin r = {sg, 31'h0};        u = 1'b1; end
      else r = {sg, e[7:0], q[22:0]};
    end
  endfunction

  // Driver: one pair per call, expected item pushed to the scoreboard.
  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] exp_res, input bit use_exp, input string tag);
    item_t it;
    logic [31:0] mr;
    logic mo, mu;
    @(negedge clk);
    in_valid = 1'b1;
    op_a     = a;
    op_b     = b;
    ref_mul(a, b, mr, mo, mu);
    it.res   = use_exp ? exp_res : mr;
    it.ovf   = mo;
    it.unf   = mu;
    it.issue = cyc;
    it.tag   = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Monitor: pops and compares as results appear.
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R1 unexpected out_valid", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(result == it.res, {it.tag, " result"}, result, it.res);
          check(ovf == it.ovf && unf == it.unf, {it.tag, " R6 R7 flags {ovf,unf}"},
                {30'd0, ovf, unf}, {30'd0, it.ovf, it.unf});
          check(cyc - it.issue == 3, "R1 latency", 32'(cyc - it.issue), 32'd3);
        end
      end else if (ovf || unf) begin
        check(1'b0, "R11 flag without out_valid", {30'd0, ovf, unf}, 32'd0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op_a     = '0;
    op_b     = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!out_valid && !ovf && !unf, "R10 outputs in reset",
          {29'd0, out_valid, ovf, unf}, 32'd0);
    rst_n = 1'b1;
    idle(4);
    check(!out_valid && !ovf && !unf, "R10 outputs after release",
          {29'd0, out_valid, ovf, unf}, 32'd0);
    mon_en = 1;

    // R3: plain products and normalization
    drive(32'h40000000, 32'h40400000, 32'h40C00000, 1, "R3 2*3");
    drive(32'h3FC00000, 32'h3FC00000, 32'h40100000, 1, "R3 1.5*1.5");
    // R2: sign
    drive(32'hBF400000, 32'h40A00000, 32'hC0700000, 1, "R2 -0.75*5");
    drive(32'hBF800000, 32'hBF800000, 32'h3F800000, 1, "R2 -1*-1");
    // R4: rounding
    drive(32'h3F800001, 32'h3F800001, 32'h3F800002, 1, "R4 round down sticky");
    drive(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1, "R4 tie to even up");
    drive(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 1, "R4 tie to even down");
    drive(32'h3F918E00, 32'h3FE12000, 32'h40000000, 1, "R4 rounding carry");
    // R5: zero operands
    drive(32'h00000000, 32'h40400000, 32'h00000000, 1, "R5 zero*3");
    drive(32'h80000000, 32'h40400000, 32'h80000000, 1, "R5 -0*3");
    drive(32'h00000001, 32'h40000000, 32'h00000000, 1, "R5 subnormal flush");
    // R6: overflow and its edge
    drive(32'h7F000000, 32'h40000000, 32'h7F800000, 1, "R6 overflow");
    drive(32'hFF000000, 32'h40000000, 32'hFF800000, 1, "R6 negative overflow");
    drive(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 1, "R6 max no overflow");
    // R7: underflow and its edge
    drive(32'h00800000, 32'h3F000000, 32'h00000000, 1, "R7 underflow");
    drive(32'h80800000, 32'h3F000000, 32'h80000000, 1, "R7 negative underflow");
    drive(32'h00800000, 32'h3F800000, 32'h00800000, 1, "R7 min no underflow");
    // R8: NaN
    drive(32'h7FC00001, 32'h3F800000, 32'h7FC00000, 1, "R8 nan operand");
    drive(32'h7F800000, 32'h00000000, 32'h7FC00000, 1, "R8 inf*0");
    // R9: infinity
    drive(32'h7F800000, 32'hC0000000, 32'hFF800000, 1, "R9 inf*-2");
    drive(32'hFF800000, 32'hFF800000, 32'h7F800000, 1, "R9 -inf*-inf");
    idle(6);

    // R3/R4 streaming with normal-range exponents, some gaps
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = {$urandom_range(0, 1) == 1, 8'(64 + $urandom_range(0, 126)), 23'($urandom)};
      b = {$urandom_range(0, 1) == 1, 8'(64 + $urandom_range(0, 126)), 23'($urandom)};
      drive(a, b, 32'h0, 0, "R3 random");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    // R6/R7 streaming over the whole exponent range
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = {$urandom_range(0, 1) == 1, 8'($urandom_range(1, 254)), 23'($urandom)};
      b = {$urandom_range(0, 1) == 1, 8'($urandom_range(1, 254)), 23'($urandom)};
      drive(a, b, 32'h0, 0, "R6 R7 random");
    end
    idle(8);
    check(sbq.size() == 0, "R1 results outstanding", 32'(sbq.size()), 32'd0);
    finish_run();
  end

endmodule